// File: doc/BRIEF.md
# Sensor Conversion Control and Threshold Comparator

This block is the software-facing control point for a sensing converter. A small register port reaches one 8-bit control/status register and a 16-bit threshold held as two bytes. Software sets the converter's enable, asks for conversions, and enables a digital comparator. The block decodes each start request against a 3-bit conversion-mode input. If the request is accepted, it sends the converter a one-cycle start pulse and tracks the busy state until a result arrives.

Each result enters on a valid/ready channel. `res_ready_o` is held high at all times, so the block never applies back-pressure. A result counts as delivered in every cycle where `res_valid_i` is high. Each delivered result sets a sticky completion flag. When the comparator is enabled, each result is also checked against the threshold, and a result strictly greater than it sets a sticky compare flag. Both flags stay set until software clears them. A greater-than event opens a short guard window. During that window, register writes are dropped, which models the settling time after a wake.

Top module: `sense_ctl`

Address map: 0 = control, 1 = threshold low byte, 2 = threshold high byte, 3 = no register (reads 0). Control bits: 7 enable, 5 completion flag, 4 busy/start, 3 comparator enable, 0 compare flag.

## Requirements
- R1: After reset, every register reads 0, and `conv_en_o`, `conv_start_o`, `irq_o` and `access_blocked_o` are all 0.
- R2: Control bit 7 is the enable. Its written value drives `conv_en_o` from the next cycle and reads back.
- R3: Control bit 5 is set by every result handshake. Writing 0 to it clears it, and writing 1 to it has no effect.
- R4: A control write with bit 4 = 1 and bit 7 = 1 produces a one-cycle `conv_start_o` pulse in the following cycle. This happens only when the enable is already 1, no conversion is busy, and `mode_i` is 000b, 110b or 111b. Otherwise the request is ignored. Writing 0 to bit 4 does nothing.
- R5: Control bit 4 reads 1 from an accepted start until a result handshake or a control write with bit 7 = 0.
- R6: On a result handshake with bit 3 = 1, bit 0 is set when the unsigned result is strictly greater than {high byte, low byte}. An equal or smaller result leaves it unchanged. Writing 0 to bit 0 clears it.
- R7: When a flag is set by hardware and cleared by a write in the same cycle, the set wins.
- R8: Control bits 6, 2 and 1 and address 3 read 0, and writes to them are ignored.
- R9: A greater-than event raises `access_blocked_o` for the next 2 cycles. Register writes made in those cycles are ignored.
- R10: `irq_o` is bit 5 OR (bit 0 AND bit 3).
- R11: `res_ready_o` is always 1 after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr` (combinational) |
| mode_i | input | 3 | Conversion-mode field |
| conv_en_o | output | 1 | Converter enable (0 = low power) |
| conv_start_o | output | 1 | One-cycle conversion start |
| res_valid_i | input | 1 | Result valid |
| res_ready_o | output | 1 | Result ready (always 1) |
| res_data_i | input | 16 | Accumulated result |
| irq_o | output | 1 | Interrupt request |
| access_blocked_o | output | 1 | Guard window active |

## Verification
Each write or handshake takes effect at the clock edge that samples it, so `reg_rdata`, `conv_en_o`, `irq_o` and `access_blocked_o` change right after that edge. `conv_start_o` rises at the same edge as the write and falls one edge later. The bench drives inputs on the falling edge and lets one rising edge pass. At the next falling edge it compares every output with a cycle model that is stepped once per rising edge. This means each result is checked in the exact cycle it is due. Directed steps cover rejected modes, a start while busy, set-versus-clear collisions, an equal-threshold result and writes inside the guard window. Seeded random traffic covers the rest.

// File: rtl/sense_pkg.sv
package sense_pkg;
  localparam int MODE_W  = 3;
  localparam int BIT_EN  = 7;
  localparam int BIT_DON = 5;
  localparam int BIT_BSY = 4;
  localparam int BIT_CEN = 3;
  localparam int BIT_CMP = 0;

  function automatic logic mode_ok(input logic [MODE_W-1:0] m);
    return (m == 3'b000) || (m == 3'b110) || (m == 3'b111);
  endfunction
endpackage

// File: rtl/sense_start.sv
module sense_start
  import sense_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_i,
  input  logic              en_i,
  input  logic [MODE_W-1:0] mode_i,
  input  logic              done_i,
  input  logic              dis_i,
  output logic              start_o,
  output logic              busy_o
);
  logic take;
  assign take = req_i && en_i && !busy_o && mode_ok(mode_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      start_o <= 1'b0;
      busy_o  <= 1'b0;
    end else begin
      start_o <= take;
      if (take)                busy_o <= 1'b1;
      else if (done_i || dis_i) busy_o <= 1'b0;
    end
  end

  assert_start_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
    start_o |=> !start_o);
  assert_start_mode_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(start_o) |-> $past(mode_ok(mode_i) && en_i));
  assert_busy_with_start_R5: assert property (@(posedge clk) disable iff (!rst_n)
    start_o |-> busy_o);
endmodule

// File: rtl/sense_cmp.sv
module sense_cmp #(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          res_valid_i,
  input  logic [DW-1:0] res_i,
  input  logic [DW-1:0] thr_i,
  input  logic          cmpen_i,
  input  logic          clr_done_i,
  input  logic          clr_cmp_i,
  output logic          done_flag_o,
  output logic          cmp_flag_o,
  output logic          gt_o
);
  assign gt_o = res_valid_i && cmpen_i && (res_i > thr_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_flag_o <= 1'b0;
      cmp_flag_o  <= 1'b0;
    end else begin
      if (res_valid_i)     done_flag_o <= 1'b1;
      else if (clr_done_i) done_flag_o <= 1'b0;
      if (gt_o)            cmp_flag_o  <= 1'b1;
      else if (clr_cmp_i)  cmp_flag_o  <= 1'b0;
    end
  end

  assert_cmp_rise_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cmp_flag_o) |-> $past(res_valid_i && cmpen_i && (res_i > thr_i)));
  assert_done_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(done_flag_o) |-> $past(clr_done_i && !res_valid_i));
  assert_set_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid_i |=> done_flag_o);
endmodule

// File: rtl/sense_guard.sv
module sense_guard #(
  parameter int CYC = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic trig_i,
  output logic blocked_o
);
  localparam int CW = $clog2(CYC + 1);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= '0;
    else if (trig_i)     cnt <= CW'(CYC);
    else if (cnt != '0)  cnt <= cnt - 1'b1;
  end
  assign blocked_o = (cnt != '0);

  assert_guard_open_R9: assert property (@(posedge clk) disable iff (!rst_n)
    trig_i |=> blocked_o);
endmodule

// File: rtl/sense_ctl.sv
module sense_ctl
  import sense_pkg::*;
#(
  parameter int DW      = 16,
  parameter int AW      = 2,
  parameter int GUARD_C = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [AW-1:0]     reg_addr,
  input  logic [7:0]        reg_wdata,
  output logic [7:0]        reg_rdata,
  input  logic [MODE_W-1:0] mode_i,
  output logic              conv_en_o,
  output logic              conv_start_o,
  input  logic              res_valid_i,
  output logic              res_ready_o,
  input  logic [DW-1:0]     res_data_i,
  output logic              irq_o,
  output logic              access_blocked_o
);
  localparam int NB = DW / 8;

  logic          en_q, cmpen_q, busy, done_f, cmp_f, gt;
  logic          wr_ok, wr_ctrl;
  logic [DW-1:0] thr_q;
  logic [7:0]    ctrl_rd;

  assign wr_ok   = reg_we && !access_blocked_o;
  assign wr_ctrl = wr_ok && (reg_addr == '0);
  assign res_ready_o = 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q    <= 1'b0;
      cmpen_q <= 1'b0;
    end else if (wr_ctrl) begin
      en_q    <= reg_wdata[BIT_EN];
      cmpen_q <= reg_wdata[BIT_CEN];
    end
  end

  for (genvar b = 0; b < NB; b++) begin : g_thr
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) thr_q[8*b +: 8] <= '0;
      else if (wr_ok && (reg_addr == AW'(b + 1))) thr_q[8*b +: 8] <= reg_wdata;
    end
  end

  sense_start u_start (
    .clk     (clk),
    .rst_n   (rst_n),
    .req_i   (wr_ctrl && reg_wdata[BIT_BSY] && reg_wdata[BIT_EN]),
    .en_i    (en_q),
    .mode_i  (mode_i),
    .done_i  (res_valid_i),
    .dis_i   (wr_ctrl && !reg_wdata[BIT_EN]),
    .start_o (conv_start_o),
    .busy_o  (busy)
  );

  sense_cmp #(.DW(DW)) u_cmp (
    .clk         (clk),
    .rst_n       (rst_n),
    .res_valid_i (res_valid_i),
    .res_i       (res_data_i),
    .thr_i       (thr_q),
    .cmpen_i     (cmpen_q),
    .clr_done_i  (wr_ctrl && !reg_wdata[BIT_DON]),
    .clr_cmp_i   (wr_ctrl && !reg_wdata[BIT_CMP]),
    .done_flag_o (done_f),
    .cmp_flag_o  (cmp_f),
    .gt_o        (gt)
  );

  sense_guard #(.CYC(GUARD_C)) u_guard (
    .clk       (clk),
    .rst_n     (rst_n),
    .trig_i    (gt),
    .blocked_o (access_blocked_o)
  );

  always_comb begin
    ctrl_rd          = '0;
    ctrl_rd[BIT_EN]  = en_q;
    ctrl_rd[BIT_DON] = done_f;
    ctrl_rd[BIT_BSY] = busy;
    ctrl_rd[BIT_CEN] = cmpen_q;
    ctrl_rd[BIT_CMP] = cmp_f;
    reg_rdata = '0;
    if (reg_addr == '0) reg_rdata = ctrl_rd;
    for (int b = 0; b < NB; b++)
      if (reg_addr == AW'(b + 1)) reg_rdata = thr_q[8*b +: 8];
  end

  assign conv_en_o = en_q;
  assign irq_o     = done_f | (cmp_f & cmpen_q);

  assert_blocked_thr_R9: assert property (@(posedge clk) disable iff (!rst_n)
    access_blocked_o |=> ($stable(thr_q) && $stable(en_q) && $stable(cmpen_q)));
  assert_unused_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == '0) |-> (reg_rdata[6] == 1'b0 && reg_rdata[2:1] == 2'b00));
  assert_start_enabled_R4: assert property (@(posedge clk) disable iff (!rst_n)
    conv_start_o |-> conv_en_o);
endmodule

// File: tb/sense_ctl_tb.sv
module sense_ctl_tb;
  logic clk = 0, rst_n = 0;
  logic reg_we = 0; logic [1:0] reg_addr = 0; logic [7:0] reg_wdata = 0;
  logic [7:0] reg_rdata; logic [2:0] mode_i = 0;
  logic conv_en_o, conv_start_o, res_valid_i = 0, res_ready_o, irq_o, access_blocked_o;
  logic [15:0] res_data_i = 0;
  int checks = 0, fails = 0;
  bit done = 0;

  sense_ctl u_dut (.clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mode_i(mode_i), .conv_en_o(conv_en_o),
    .conv_start_o(conv_start_o), .res_valid_i(res_valid_i), .res_ready_o(res_ready_o),
    .res_data_i(res_data_i), .irq_o(irq_o), .access_blocked_o(access_blocked_o));

  always #10 clk = ~clk;

  // cycle model built from the requirements
  bit m_en, m_cen, m_don, m_cmp, m_bsy, m_st; logic [15:0] m_thr; int m_g;

  function automatic bit good_mode(logic [2:0] m);
    return m == 3'd0 || m == 3'd6 || m == 3'd7;
  endfunction

  function automatic logic [7:0] m_read(logic [1:0] a);
    case (a)
      2'd0: return {m_en, 1'b0, m_don, m_bsy, m_cen, 2'b00, m_cmp};
      2'd1: return m_thr[7:0];
      2'd2: return m_thr[15:8];
      default: return 8'h00;
    endcase
  endfunction

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic step(bit we, logic [1:0] a, logic [7:0] wd, logic [2:0] md, bit rv, logic [15:0] rs);
    bit w, wc, st, gt;
    reg_we = we; reg_addr = a; reg_wdata = wd; mode_i = md; res_valid_i = rv; res_data_i = rs;
    @(posedge clk);
    w  = we && (m_g == 0);
    wc = w && a == 2'd0;
    st = wc && wd[4] && wd[7] && m_en && !m_bsy && good_mode(md);
    gt = rv && m_cen && (rs > m_thr);
    m_st = st;
    if (st) m_bsy = 1; else if (rv || (wc && !wd[7])) m_bsy = 0;
    if (rv) m_don = 1; else if (wc && !wd[5]) m_don = 0;
    if (gt) m_cmp = 1; else if (wc && !wd[0]) m_cmp = 0;
    if (gt) m_g = 2; else if (m_g > 0) m_g--;
    if (wc) begin m_en = wd[7]; m_cen = wd[3]; end
    if (w && a == 2'd1) m_thr[7:0] = wd;
    if (w && a == 2'd2) m_thr[15:8] = wd;
    @(negedge clk);
    chk("R2 conv_en", conv_en_o, m_en);
    chk("R4 start", conv_start_o, m_st);
    chk("R9 blocked", access_blocked_o, m_g != 0);
    chk("R10 irq", irq_o, m_don | (m_cmp & m_cen));
    chk("R11 ready", res_ready_o, 1);
    chk("R8 rdata", reg_rdata, m_read(a));
    if (a == 2'd0) begin
      chk("R3 done flag", reg_rdata[5], m_don);
      chk("R5 busy", reg_rdata[4], m_bsy);
      chk("R6 cmp flag", reg_rdata[0], m_cmp);
    end
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    m_en = 0; m_cen = 0; m_don = 0; m_cmp = 0; m_bsy = 0; m_st = 0; m_thr = 0; m_g = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1 ctrl", reg_rdata, 0);
    chk("R1 outs", {conv_en_o, conv_start_o, irq_o, access_blocked_o}, 0);
    step(0, 2'd1, 0, 0, 0, 0); chk("R1 thr lo", reg_rdata, 0);
    step(0, 2'd2, 0, 0, 0, 0); chk("R1 thr hi", reg_rdata, 0);
    // directed
    step(1, 2'd0, 8'h90, 3'd0, 0, 0);   // R4 start while disabled: ignored
    chk("R4 disabled start", conv_start_o, 0);
    step(1, 2'd0, 8'hC6, 3'd0, 0, 0);   // R8 enable, unused bits written 1
    chk("R8 unused", reg_rdata, 8'h80);
    step(1, 2'd0, 8'h90, 3'd3, 0, 0);   // R4 bad mode
    chk("R4 bad mode", conv_start_o, 0);
    step(1, 2'd0, 8'h90, 3'd6, 0, 0);   // R4 good mode
    chk("R4 good mode", conv_start_o, 1);
    step(1, 2'd0, 8'h90, 3'd7, 0, 0);   // R4 busy: ignored
    chk("R4 start while busy", conv_start_o, 0);
    chk("R5 busy held", reg_rdata[4], 1);
    step(1, 2'd1, 8'h34, 3'd0, 0, 0);
    step(1, 2'd2, 8'h12, 3'd0, 0, 0);
    step(1, 2'd0, 8'h88, 3'd0, 0, 0);   // enable comparator
    step(0, 2'd0, 0, 3'd0, 1, 16'h1234); // equal: no cmp
    chk("R6 equal", reg_rdata[0], 0);
    chk("R5 busy cleared", reg_rdata[4], 0);
    step(1, 2'd0, 8'h88, 3'd0, 1, 16'h0001); // R7 set wins over clear
    chk("R7 set wins", reg_rdata[5], 1);
    step(1, 2'd0, 8'hA8, 3'd0, 0, 0);   // R3 writing 1 keeps
    step(0, 2'd0, 0, 3'd0, 1, 16'h1235); // greater: cmp + guard
    chk("R6 greater", reg_rdata[0], 1);
    step(1, 2'd1, 8'hFF, 3'd0, 0, 0);   // R9 blocked write
    step(1, 2'd1, 8'hEE, 3'd0, 0, 0);   // R9 still blocked
    chk("R9 thr kept", reg_rdata, 8'h34);
    step(1, 2'd1, 8'h01, 3'd0, 0, 0);   // accepted
    chk("R9 write after window", reg_rdata, 8'h01);
    step(1, 2'd0, 8'h80, 3'd0, 0, 0);   // clear flags, comparator off
    chk("R10 irq clear", irq_o, 0);
    // random
    void'($urandom(32'h5EED_0042));
    for (int i = 0; i < 1500; i++) begin
      logic [7:0] wd; logic [2:0] md;
      wd = 8'($urandom);
      md = ($urandom % 2) ? 3'($urandom) : 3'd6;
      step(($urandom % 3) == 0, 2'($urandom), wd, md, ($urandom % 6) == 0, 16'($urandom));
    end
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule